// File: doc/BRIEF.md
# Addressed Three-Wire Serial Configuration Loader

This block takes configuration words from an external controller over a three-line bus: a serial data line, an active-low enable line and a shift clock. While enable is low, each rising shift-clock edge moves one data bit into a frame register. When enable returns high, the block checks the frame. It must hold exactly 22 bits, and its two leading bits must equal the device address set by a parameter. Only then are the 14-bit divide code and the 6 function bits copied into holding registers, which drive the output pins. Several devices can share one bus because each one commits only frames that carry its own address.

The three bus lines are asynchronous to the block. Each one passes through a synchroniser clocked by the fast system clock, and the edges are detected in that clock domain. The latched outputs are plain levels with no handshake, so there is no back-pressure. A one-cycle pulse marks every commit so that a consumer can resample the outputs. One function bit also selects the band (FM or AM) and is driven out on a dedicated pin.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset, div_code_o is 0, func_o is 0, band_fm_o is 0 and updated_o is 0.
- R2: Bits are taken on rising shift-clock edges while enable is low, with the first bit received as frame bit 21. Frame bits 21:20 are the address, bits 19:6 go to div_code_o and bits 5:0 go to func_o.
- R3: Shift-clock edges while enable is high shift nothing and change no output.
- R4: Outputs change only on a rising enable edge. While a frame is being shifted in, they keep their previous values.
- R5: A frame whose bits 21:20 differ from DEV_ADDR leaves the outputs unchanged and raises no pulse.
- R6: A frame with fewer or more than 22 bits when enable rises is discarded, and the outputs stay unchanged.
- R7: updated_o goes high for exactly one system-clock cycle for each accepted frame, in the cycle the new outputs appear.
- R8: band_fm_o equals func_o[2], which is the fourth function bit received. A 1 selects FM and a 0 selects AM.
- R9: The bit count restarts on every falling edge of enable, so a frame that was aborted earlier has no effect on the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_clk_i | input | 1 | Serial shift clock, asynchronous |
| bus_data_i | input | 1 | Serial data, asynchronous |
| bus_en_i | input | 1 | Bus enable: low while shifting, rising edge commits |
| div_code_o | output | 14 | Latched divide code |
| func_o | output | 6 | Latched function bits |
| band_fm_o | output | 1 | Band select: 1 means FM, 0 means AM |
| updated_o | output | 1 | One-cycle pulse when new values are latched |

## Verification
The hardest case to reach from the ports is a frame that is well formed in every respect except what came before it. Here an aborted partial frame is followed directly by a new enable-low window, and only a correct count restart lets the second frame through. The bench shifts 10 bits, raises enable, then lowers it again and sends a full matching frame, so any bits carried over would push the count to 32 and cause the frame to be discarded. Frames one bit short and one bit long, and frames with a foreign address, test the rejection paths through outputs that must not move.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  localparam int CFGL_ADDR_W  = 2;
  localparam int CFGL_CODE_W  = 14;
  localparam int CFGL_FUNC_W  = 6;
  localparam int CFGL_FRAME_W = CFGL_ADDR_W + CFGL_CODE_W + CFGL_FUNC_W;

  typedef enum logic {
    BAND_AM = 1'b0,
    BAND_FM = 1'b1
  } band_e;

  // Index of each bus line inside the synchroniser vector
  localparam int LINE_CLK  = 0;
  localparam int LINE_DATA = 1;
  localparam int LINE_EN   = 2;
  localparam int LINES     = 3;
endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
  parameter int           W      = 3,
  parameter int           STAGES = 2,
  parameter logic [W-1:0] INIT   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= INIT;
      prev_q <= INIT;
    end else begin
      stg_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~prev_q;
  assign fall_o = ~stg_q[STAGES-1] & prev_q;
endmodule

// File: rtl/cfgl_shifter.sv
module cfgl_shifter #(
  parameter int FRAME_W = 22,
  localparam int CNT_W  = $clog2(FRAME_W + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart_i,
  input  logic               shift_i,
  input  logic               din_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   cnt_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (shift_i) begin
      sr_q <= {sr_q[FRAME_W-2:0], din_i};
      if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign frame_o = sr_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/cfgl_latch.sv
module cfgl_latch #(
  parameter int                  ADDR_W   = 2,
  parameter int                  CODE_W   = 14,
  parameter int                  FUNC_W   = 6,
  parameter logic [ADDR_W-1:0]   DEV_ADDR = '0,
  localparam int FRAME_W = ADDR_W + CODE_W + FUNC_W,
  localparam int CNT_W   = $clog2(FRAME_W + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   cnt_i,
  output logic [CODE_W-1:0]  code_o,
  output logic [FUNC_W-1:0]  func_o,
  output logic               upd_o
);
  logic [ADDR_W-1:0] addr_f;
  logic [CODE_W-1:0] code_f;
  logic [FUNC_W-1:0] func_f;
  logic              accept;

  assign addr_f = frame_i[FRAME_W-1 -: ADDR_W];
  assign code_f = frame_i[FUNC_W +: CODE_W];
  assign func_f = frame_i[FUNC_W-1:0];
  assign accept = commit_i && (cnt_i == CNT_W'(FRAME_W)) && (addr_f == DEV_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o <= '0;
      func_o <= '0;
      upd_o  <= 1'b0;
    end else begin
      upd_o <= accept;
      if (accept) begin
        code_o <= code_f;
        func_o <= func_f;
      end
    end
  end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfgl_pkg::*;
#(
  parameter int                ADDR_W      = CFGL_ADDR_W,
  parameter int                CODE_W      = CFGL_CODE_W,
  parameter int                FUNC_W      = CFGL_FUNC_W,
  parameter logic [ADDR_W-1:0] DEV_ADDR    = 2'b10,
  parameter int                SYNC_STAGES = 2,
  parameter int                BAND_IDX    = 2,
  localparam int FRAME_W = ADDR_W + CODE_W + FUNC_W,
  localparam int CNT_W   = $clog2(FRAME_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_clk_i,
  input  logic              bus_data_i,
  input  logic              bus_en_i,
  output logic [CODE_W-1:0] div_code_o,
  output logic [FUNC_W-1:0] func_o,
  output logic              band_fm_o,
  output logic              updated_o
);
  // Enable idles high; reset its synchroniser there so that no edge is seen
  localparam logic [LINES-1:0] SYNC_INIT = LINES'(1) << LINE_EN;

  logic [LINES-1:0]   raw, lvl, rise, fall;
  logic [FRAME_W-1:0] frame_q;
  logic [CNT_W-1:0]   bit_cnt;
  logic               shift_go;
  band_e              band;

  assign raw[LINE_CLK]  = bus_clk_i;
  assign raw[LINE_DATA] = bus_data_i;
  assign raw[LINE_EN]   = bus_en_i;

  cfgl_sync #(.W(LINES), .STAGES(SYNC_STAGES), .INIT(SYNC_INIT)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(raw),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  assign shift_go = rise[LINE_CLK] & ~lvl[LINE_EN];

  cfgl_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .restart_i(fall[LINE_EN]), .shift_i(shift_go), .din_i(lvl[LINE_DATA]),
    .frame_o(frame_q), .cnt_o(bit_cnt)
  );

  cfgl_latch #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .FUNC_W(FUNC_W), .DEV_ADDR(DEV_ADDR)) u_latch (
    .clk(clk), .rst_n(rst_n),
    .commit_i(rise[LINE_EN]), .frame_i(frame_q), .cnt_i(bit_cnt),
    .code_o(div_code_o), .func_o(func_o), .upd_o(updated_o)
  );

  assign band      = band_e'(func_o[BAND_IDX]);
  assign band_fm_o = (band == BAND_FM);
endmodule

// File: rtl/cfgl_chk.sv
module cfgl_chk #(
  parameter int                ADDR_W   = 2,
  parameter int                CODE_W   = 14,
  parameter int                FUNC_W   = 6,
  parameter logic [ADDR_W-1:0] DEV_ADDR = '0,
  localparam int FRAME_W = ADDR_W + CODE_W + FUNC_W,
  localparam int CNT_W   = $clog2(FRAME_W + 2)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CODE_W-1:0]  div_code_o,
  input logic [FUNC_W-1:0]  func_o,
  input logic               updated_o,
  input logic [CNT_W-1:0]   bit_cnt,
  input logic [FRAME_W-1:0] frame_q
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (div_code_o == '0 && func_o == '0 && !updated_o));

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    updated_o |=> !updated_o);

  // R4
  change_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(div_code_o) || !$stable(func_o)) |-> updated_o);

  // R6
  full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    updated_o |-> ($past(bit_cnt) == CNT_W'(FRAME_W)));

  // R5
  addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    updated_o |-> ($past(frame_q[FRAME_W-1 -: ADDR_W]) == DEV_ADDR));
endmodule

bind serial_cfg_loader cfgl_chk #(
  .ADDR_W(ADDR_W), .CODE_W(CODE_W), .FUNC_W(FUNC_W), .DEV_ADDR(DEV_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .div_code_o(div_code_o), .func_o(func_o),
  .updated_o(updated_o), .bit_cnt(bit_cnt), .frame_q(frame_q)
);

// File: tb/serial_cfg_loader_tb.sv
module serial_cfg_loader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PH = 4;
  localparam logic [1:0] MY_ADDR = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, bdat = 1'b0, ben = 1'b1;
  logic [13:0] div_code;
  logic [5:0]  func;
  logic        band_fm, updated;

  int checks = 0, fails = 0, pulses = 0;
  logic [13:0] exp_code = '0;
  logic [5:0]  exp_func = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cfg_loader u_dut (
    .clk(clk), .rst_n(rst_n), .bus_clk_i(bclk), .bus_data_i(bdat), .bus_en_i(ben),
    .div_code_o(div_code), .func_o(func), .band_fm_o(band_fm), .updated_o(updated)
  );

  always @(negedge clk) if (rst_n && updated) pulses++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    bdat = b; wclk(PH);
    bclk = 1'b1; wclk(PH);
    bclk = 1'b0; wclk(PH);
  endtask

  // Shift nbits of the frame {addr, code, func}, first bit = frame bit 21
  task automatic shift_bits(input logic [1:0] a, input logic [13:0] c, input logic [5:0] f,
                            input int nbits);
    logic [21:0] fr;
    fr = {a, c, f};
    ben = 1'b0; wclk(PH);
    for (int i = 0; i < nbits; i++) put_bit(i < 22 ? fr[21-i] : 1'b0);
  endtask

  task automatic close_frame();
    ben = 1'b1; wclk(3 * PH);
  endtask

  task automatic expect_outputs(input string req);
    chk(div_code == exp_code, req, div_code, exp_code);
    chk(func == exp_func, req, func, exp_func);
  endtask

  task automatic t_reset();
    chk(div_code == 0 && func == 0, "R1", {div_code, func}, 0);
    chk(band_fm == 1'b0, "R1", band_fm, 0);
    chk(updated == 1'b0, "R1", updated, 0);
  endtask

  task automatic t_basic();
    int p0;
    p0 = pulses;
    shift_bits(MY_ADDR, 14'h2AB5, 6'b101101, 22);
    // R4: nothing moves before enable rises
    expect_outputs("R4");
    chk(pulses == p0, "R4", pulses - p0, 0);
    close_frame();
    exp_code = 14'h2AB5; exp_func = 6'b101101;
    expect_outputs("R2");
    chk(band_fm == 1'b1, "R8", band_fm, 1);
    chk(pulses == p0 + 1, "R7", pulses - p0, 1);
  endtask

  task automatic t_second();
    int p0;
    p0 = pulses;
    shift_bits(MY_ADDR, 14'h3FFF, 6'b111011, 22);
    close_frame();
    exp_code = 14'h3FFF; exp_func = 6'b111011;
    expect_outputs("R2");
    chk(band_fm == 1'b0, "R8", band_fm, 0);
    chk(pulses == p0 + 1, "R7", pulses - p0, 1);
  endtask

  task automatic t_mismatch();
    int p0;
    p0 = pulses;
    shift_bits(2'b01, 14'h0123, 6'b000100, 22);
    close_frame();
    expect_outputs("R5");
    chk(pulses == p0, "R5", pulses - p0, 0);
  endtask

  task automatic t_bad_length(input int n);
    int p0;
    p0 = pulses;
    shift_bits(MY_ADDR, 14'h1111, 6'b010101, n);
    close_frame();
    expect_outputs("R6");
    chk(pulses == p0, "R6", pulses - p0, 0);
  endtask

  task automatic t_clk_while_high();
    int p0;
    p0 = pulses;
    ben = 1'b1;
    for (int i = 0; i < 24; i++) put_bit(i[0]);
    wclk(3 * PH);
    expect_outputs("R3");
    chk(pulses == p0, "R3", pulses - p0, 0);
  endtask

  task automatic t_abort_restart();
    int p0;
    p0 = pulses;
    shift_bits(MY_ADDR, 14'h0F0F, 6'b110000, 10);
    close_frame();
    chk(pulses == p0, "R9", pulses - p0, 0);
    shift_bits(MY_ADDR, 14'h1234, 6'b000101, 22);
    close_frame();
    exp_code = 14'h1234; exp_func = 6'b000101;
    expect_outputs("R9");
    chk(band_fm == 1'b1, "R8", band_fm, 1);
    chk(pulses == p0 + 1, "R9", pulses - p0, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    wclk(5);
    t_reset();
    rst_n = 1'b1;
    wclk(5);
    t_reset();
    t_basic();
    t_second();
    t_mismatch();
    t_bad_length(21);
    t_bad_length(23);
    t_clk_while_high();
    t_abort_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule